// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a group of interrupting devices and a processor. Each device raises a level request. The controller picks the most urgent eligible request and presents a single interrupt line to the processor. Once the processor signals that it can take an interrupt, the controller acknowledges the chosen device for one cycle and captures the vector that the device drives back. It then turns that vector into a handler address by indexing a table whose base address is an input.

The controller keeps a stack of the priority levels now being serviced. A request is recognised only when it outranks the top of that stack, so nesting happens only upward. A completion strobe from the processor retires the innermost handler. Any source can be masked through a write port. A separate non-maskable input is edge-triggered. It carries its own fixed vector and passes both the mask and the in-service blocking of maskable levels.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Ranking is fixed. The non-maskable source comes first. Then come the sources marked fast in parameter FAST_SRC, lowest index first. Then come the other sources, lowest index first. Only the single best eligible source is acknowledged.
- R2: `cpu_irq` is high in the idle state whenever an eligible source exists. A grant happens on a clock edge where both `cpu_irq` and `cpu_ack` are high. In the cycle after that edge, exactly one `dev_ack` bit is high, and it stays high for that one cycle only. `cpu_irq` is low during that cycle.
- R3: The vector is sampled at the end of the acknowledge cycle. In the next cycle, `handler_valid` pulses for one cycle. `handler_addr` then equals `vec_base + vector*4` and holds until the next capture.
- R4: A maskable request whose rank is equal to or lower than the innermost in-service rank is not recognised, and `cpu_irq` stays low for it until a completion retires that level.
- R5: A request that outranks the innermost in-service level is serviced at once and pushes a new level. Each `svc_done` pulse removes only the innermost level, so the outer level blocks again.
- R6: When `svc_done` arrives in the same cycle as a vector capture, the retired level is replaced by the new one. Only one `svc_done` is then needed before the old level's rank becomes eligible again.
- R7: If the acknowledged device drops its request during the acknowledge cycle, no vector is captured, `handler_valid` stays low, no level is pushed, and arbitration resumes in the next cycle.
- R8: A source whose bit in the mask register is 1 is not recognised. `mask_we` writes `mask_wdata` to the mask register on a clock edge. Clearing the bit lets the held request be serviced.
- R9: A rising edge on `nmi_in` latches a pending non-maskable request. It is serviced even when all sources are masked and a maskable level is in service. It raises no `dev_ack` bit, and it yields `vec_base + NMI_VEC*4`.
- R10: Reset clears the pending, in-service and mask state. After reset, `cpu_irq`, every `dev_ack` bit and `handler_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_SRC | Level request per device |
| dev_ack | output | N_SRC | One-cycle acknowledge to the selected device |
| dev_vec | input | N_SRC*VEC_W | Vector per device, source i in bits [i*VEC_W +: VEC_W] |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | N_SRC | New mask, 1 blocks the source |
| vec_base | input | ADDR_W | Base address of the handler table |
| cpu_irq | output | 1 | Interrupt to the processor |
| cpu_ack | input | 1 | Processor is ready to take the interrupt |
| svc_done | input | 1 | Completion of the innermost handler |
| handler_valid | output | 1 | One-cycle strobe for a new handler address |
| handler_addr | output | ADDR_W | Computed handler address |

## Verification
The case that needs the most care is a completion strobe and a vector capture landing in the same cycle. In that cycle the stack is asked to retire one level and push another. The bench provokes this by raising a higher request while a lower level is in service. It asserts `svc_done` exactly in the acknowledge cycle, then raises a request at the retired level's rank. That request must be serviced after a single further completion. A bench-side reference model, built on a queue of levels, is compared with the outputs on every cycle, so any wrong stack depth also shows up as a changed `cpu_irq`.

// File: rtl/irq_vector_ctrl_pkg.sv
package irq_vector_ctrl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } ivc_state_e;

    // handler entries are word-sized: vector scaled by 4
    localparam int unsigned VEC_SCALE_SH = 2;

    // rank 0 is reserved for the non-maskable source; smaller is more urgent
    function automatic int unsigned src_rank(int unsigned idx, logic fast, int unsigned n);
        return 1 + idx + (fast ? 0 : n);
    endfunction

    function automatic int unsigned empty_rank(int unsigned n);
        return 2 * n + 1;
    endfunction

endpackage

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import irq_vector_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC    = 4,
    parameter int unsigned RANK_W   = 4,
    parameter int unsigned IDX_W    = 2,
    parameter logic [N_SRC-1:0] FAST_SRC = '0
) (
    input  logic [N_SRC-1:0]  req,
    input  logic [N_SRC-1:0]  mask,
    input  logic              nmi_pend,
    input  logic [RANK_W-1:0] cur_rank,
    output logic              any_win,
    output logic              win_nmi,
    output logic [IDX_W-1:0]  win_idx,
    output logic [RANK_W-1:0] win_rank
);

    logic [RANK_W-1:0] rank_c [N_SRC];
    logic              found;

    for (genvar g = 0; g < N_SRC; g++) begin : g_rank
        assign rank_c[g] = RANK_W'(src_rank(g, FAST_SRC[g], N_SRC));
    end

    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_rank = '1;
        win_nmi  = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && !mask[i] && (rank_c[i] < cur_rank) &&
                (!found || (rank_c[i] < win_rank))) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_rank = rank_c[i];
            end
        end
        if (nmi_pend && (cur_rank != '0)) begin
            win_nmi  = 1'b1;
            win_rank = '0;
        end
        any_win = found | win_nmi;
    end

endmodule

// File: rtl/ivc_level_stack.sv
module ivc_level_stack #(
    parameter int unsigned DEPTH      = 5,
    parameter int unsigned RANK_W     = 4,
    parameter int unsigned EMPTY_RANK = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [RANK_W-1:0] push_rank,
    input  logic              pop,
    output logic [RANK_W-1:0] top_rank
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [RANK_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;

    assign top_rank = (cnt == '0) ? RANK_W'(EMPTY_RANK) : mem[cnt - 1'b1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && pop && (cnt != '0)) begin
            mem[cnt - 1'b1] <= push_rank;
        end else if (push && (cnt != CNT_W'(DEPTH))) begin
            mem[cnt] <= push_rank;
            cnt      <= cnt + 1'b1;
        end else if (pop && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ivc_nmi_latch.sv
module ivc_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic taken,
    output logic pend
);

    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            pend  <= (nmi_in && !nmi_q) || (pend && !taken);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC   = 4,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter logic [N_SRC-1:0] FAST_SRC = 4'b1000,
    parameter logic [VEC_W-1:0] NMI_VEC  = 8'h02
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SRC-1:0]         dev_req,
    output logic [N_SRC-1:0]         dev_ack,
    input  logic [N_SRC*VEC_W-1:0]   dev_vec,
    input  logic                     nmi_in,
    input  logic                     mask_we,
    input  logic [N_SRC-1:0]         mask_wdata,
    input  logic [ADDR_W-1:0]        vec_base,
    output logic                     cpu_irq,
    input  logic                     cpu_ack,
    input  logic                     svc_done,
    output logic                     handler_valid,
    output logic [ADDR_W-1:0]        handler_addr
);

    localparam int unsigned IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int unsigned EMPTY_RK   = empty_rank(N_SRC);
    localparam int unsigned RANK_W     = $clog2(EMPTY_RK + 1);
    localparam int unsigned DEPTH      = N_SRC + 1;

    ivc_state_e        state;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_nmi;
    logic [RANK_W-1:0] sel_rank;
    logic [N_SRC-1:0]  mask_q;

    logic              nmi_pend;
    logic              any_win, win_nmi;
    logic [IDX_W-1:0]  win_idx;
    logic [RANK_W-1:0] win_rank;
    logic [RANK_W-1:0] cur_rank;

    logic              grant, capture;
    logic [VEC_W-1:0]  vec_arr [N_SRC];
    logic [VEC_W-1:0]  cap_vec;

    for (genvar g = 0; g < N_SRC; g++) begin : g_dev
        assign vec_arr[g] = dev_vec[g*VEC_W +: VEC_W];
        assign dev_ack[g] = (state == ST_ACK) && !sel_nmi && (sel_idx == IDX_W'(g));
    end

    ivc_arbiter #(
        .N_SRC(N_SRC), .RANK_W(RANK_W), .IDX_W(IDX_W), .FAST_SRC(FAST_SRC)
    ) u_arb (
        .req(dev_req), .mask(mask_q), .nmi_pend(nmi_pend), .cur_rank(cur_rank),
        .any_win(any_win), .win_nmi(win_nmi), .win_idx(win_idx), .win_rank(win_rank)
    );

    ivc_level_stack #(
        .DEPTH(DEPTH), .RANK_W(RANK_W), .EMPTY_RANK(EMPTY_RK)
    ) u_stack (
        .clk(clk), .rst(rst), .push(capture), .push_rank(sel_rank),
        .pop(svc_done), .top_rank(cur_rank)
    );

    ivc_nmi_latch u_nmi (
        .clk(clk), .rst(rst), .nmi_in(nmi_in),
        .taken(grant && win_nmi), .pend(nmi_pend)
    );

    assign cpu_irq = (state == ST_IDLE) && any_win;
    assign grant   = cpu_irq && cpu_ack;
    assign capture = (state == ST_ACK) && (sel_nmi || dev_req[sel_idx]);
    assign cap_vec = sel_nmi ? NMI_VEC : vec_arr[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            sel_idx       <= '0;
            sel_nmi       <= 1'b0;
            sel_rank      <= '0;
            mask_q        <= '0;
            handler_valid <= 1'b0;
            handler_addr  <= '0;
        end else begin
            handler_valid <= 1'b0;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
            unique case (state)
                ST_IDLE: begin
                    if (grant) begin
                        state    <= ST_ACK;
                        sel_idx  <= win_idx;
                        sel_nmi  <= win_nmi;
                        sel_rank <= win_rank;
                    end
                end
                ST_ACK: begin
                    state <= ST_IDLE;
                    if (capture) begin
                        handler_valid <= 1'b1;
                        handler_addr  <= vec_base + (ADDR_W'(cap_vec) << VEC_SCALE_SH);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int unsigned N_SRC = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_irq,
    input logic             cpu_ack,
    input logic [N_SRC-1:0] dev_ack,
    input logic             handler_valid
);

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_ack)); // R1

    AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(|dev_ack) |-> $past(cpu_irq && cpu_ack)); // R2

    AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|dev_ack) |=> !(|dev_ack)); // R2

    AST_IRQ_DROPS_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq && cpu_ack) |=> !cpu_irq); // R2

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        handler_valid |=> !handler_valid); // R3

    AST_VALID_AFTER_ACK_CYCLE: assert property (@(posedge clk) disable iff (rst)
        handler_valid |-> $past(!cpu_irq)); // R3

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dev_ack == '0) && !handler_valid); // R10

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst(rst), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
    .dev_ack(dev_ack), .handler_valid(handler_valid)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    localparam int N = 4;
    localparam logic [3:0] FASTV = 4'b1000;
    localparam int NMIV = 2;
    localparam int NONE = 2 * N + 1;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  dev_req = '0;
    logic [3:0]  dev_ack;
    logic [31:0] dev_vec = {8'h23, 8'h22, 8'h21, 8'h20};
    logic        nmi_in = 1'b0;
    logic        mask_we = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic [31:0] vec_base = BASE;
    logic        cpu_irq;
    logic        cpu_ack = 1'b1;
    logic        svc_done = 1'b0;
    logic        handler_valid;
    logic [31:0] handler_addr;

    int vectors = 0;
    int fails = 0;
    bit ended = 1'b0;
    int svc[$];

    always #5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst(rst), .dev_req(dev_req), .dev_ack(dev_ack), .dev_vec(dev_vec),
        .nmi_in(nmi_in), .mask_we(mask_we), .mask_wdata(mask_wdata), .vec_base(vec_base),
        .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .svc_done(svc_done),
        .handler_valid(handler_valid), .handler_addr(handler_addr)
    );

    // ---------------- behavioural reference model ----------------
    int m_state, m_sel, m_hv;
    bit m_npend, m_nprev;
    logic [3:0] m_mask;
    logic [31:0] m_haddr;
    int m_stk[$];

    function automatic int rk(int i);
        return 1 + i + (FASTV[i] ? 0 : N);
    endfunction

    function automatic int m_cur();
        return (m_stk.size() == 0) ? NONE : m_stk[$];
    endfunction

    function automatic int m_win();
        int best = -1;
        if (m_npend && m_cur() != 0) return N;
        for (int i = 0; i < N; i++)
            if (dev_req[i] && !m_mask[i] && rk(i) < m_cur() && (best < 0 || rk(i) < rk(best)))
                best = i;
        return best;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_sel = 0; m_hv = 0; m_npend = 0; m_nprev = 0;
            m_mask = '0; m_haddr = '0; m_stk.delete();
        end else begin
            int w;
            bit push;
            int prank;
            w = m_win();
            push = 0; prank = 0;
            m_npend = (nmi_in && !m_nprev) || (m_npend && !(m_state == 0 && cpu_ack && w == N));
            m_nprev = nmi_in;
            m_hv = 0;
            if (m_state == 0) begin
                if (cpu_ack && w >= 0) begin m_sel = w; m_state = 1; end
            end else begin
                m_state = 0;
                if (m_sel == N) begin
                    push = 1; prank = 0; m_hv = 1; m_haddr = vec_base + NMIV * 4;
                end else if (dev_req[m_sel]) begin
                    push = 1; prank = rk(m_sel); m_hv = 1;
                    m_haddr = vec_base + (32'h20 + m_sel) * 4;
                end
            end
            if (svc_done && m_stk.size() > 0) void'(m_stk.pop_back());
            if (push) m_stk.push_back(prank);
            if (mask_we) m_mask = mask_wdata;
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int w;
            logic [3:0] eack;
            bit eirq;
            w = m_win();
            eirq = (m_state == 0) && (w >= 0);
            eack = (m_state == 1 && m_sel < N) ? (4'b1 << m_sel) : 4'b0;
            chk(cpu_irq == eirq, "R2 cpu_irq", cpu_irq, eirq);
            chk(dev_ack == eack, "R1 dev_ack", dev_ack, eack);
            chk(handler_valid == m_hv, "R3 handler_valid", handler_valid, m_hv);
            if (m_hv) chk(handler_addr == m_haddr, "R3 handler_addr", handler_addr, m_haddr);
            if (handler_valid) svc.push_back(int'((handler_addr - BASE) >> 2));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            logic [3:0] ackq;
            @(negedge clk);
            ackq = dev_ack;
            @(posedge clk);
            #1;
            dev_req = dev_req & ~ackq;
        end
    endtask

    task automatic wait_svc();
        int c = svc.size();
        for (int k = 0; k < 20 && svc.size() == c; k++) step(1);
    endtask

    task automatic pulse_done();
        svc_done = 1'b1; step(1); svc_done = 1'b0;
    endtask

    task automatic write_mask(logic [3:0] m);
        mask_we = 1'b1; mask_wdata = m; step(1); mask_we = 1'b0;
    endtask

    function automatic int last_svc();
        return (svc.size() == 0) ? -1 : svc[$];
    endfunction

    always begin
        @(posedge clk);
        if (!ended && $time > 400000) begin
            ended = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", $time, 400000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n0;
        step(3);
        #2;
        chk(cpu_irq == 0 && dev_ack == 0 && handler_valid == 0, "R10 reset outputs",
            {cpu_irq, dev_ack, handler_valid}, 0);
        rst = 1'b0;
        step(2);

        // R1: all four at once, processor not ready first
        cpu_ack = 1'b0;
        dev_req = 4'b1111;
        step(2);
        #2 chk(cpu_irq == 1, "R2 irq while processor busy", cpu_irq, 1);
        chk(dev_ack == 0, "R2 no ack without cpu_ack", dev_ack, 0);
        cpu_ack = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wait_svc();
            pulse_done();
        end
        chk(svc.size() == 4, "R1 services count", svc.size(), 4);
        if (svc.size() == 4) begin
            chk(svc[0] == 'h23, "R1 fast source first", svc[0], 'h23);
            chk(svc[1] == 'h20, "R1 normal index 0 next", svc[1], 'h20);
            chk(svc[2] == 'h21, "R1 normal index 1", svc[2], 'h21);
            chk(svc[3] == 'h22, "R1 normal index 2", svc[3], 'h22);
        end
        step(2);

        // R3: address formation
        dev_req[1] = 1'b1;
        wait_svc();
        #2 chk(handler_addr == BASE + 32'h21 * 4, "R3 address", handler_addr, BASE + 32'h21 * 4);
        // R4: lower request held while index 1 in service
        dev_req[2] = 1'b1;
        n0 = svc.size();
        step(4);
        #2 chk(cpu_irq == 0, "R4 lower request held", cpu_irq, 0);
        chk(svc.size() == n0, "R4 no service while held", svc.size(), n0);
        pulse_done();
        wait_svc();
        chk(last_svc() == 'h22, "R4 serviced after completion", last_svc(), 'h22);
        pulse_done();
        step(2);

        // R5: nesting
        dev_req[2] = 1'b1;
        wait_svc();
        dev_req[0] = 1'b1;
        wait_svc();
        chk(last_svc() == 'h20, "R5 nested higher request", last_svc(), 'h20);
        pulse_done();
        dev_req[2] = 1'b1;
        step(3);
        #2 chk(cpu_irq == 0, "R5 outer level blocks again", cpu_irq, 0);
        pulse_done();
        wait_svc();
        chk(last_svc() == 'h22, "R5 after outer retire", last_svc(), 'h22);
        pulse_done();
        step(2);

        // R6: completion coincides with capture
        dev_req[2] = 1'b1;
        wait_svc();
        dev_req[0] = 1'b1;
        step(1);
        svc_done = 1'b1;
        step(1);
        svc_done = 1'b0;
        step(1);
        chk(last_svc() == 'h20, "R6 capture with completion", last_svc(), 'h20);
        dev_req[2] = 1'b1;
        n0 = svc.size();
        pulse_done();
        wait_svc();
        chk(svc.size() == n0 + 1 && last_svc() == 'h22, "R6 one completion frees level",
            last_svc(), 'h22);
        pulse_done();
        step(2);

        // R7: request dropped during acknowledge
        dev_req[1] = 1'b1;
        n0 = svc.size();
        step(1);
        dev_req[1] = 1'b0;
        step(3);
        #2 chk(svc.size() == n0, "R7 no capture on drop", svc.size(), n0);
        chk(cpu_irq == 0, "R7 idle after drop", cpu_irq, 0);
        dev_req[1] = 1'b1;
        wait_svc();
        chk(last_svc() == 'h21, "R7 arbitration resumes", last_svc(), 'h21);
        pulse_done();
        step(2);

        // R8: mask register
        write_mask(4'b0001);
        dev_req[0] = 1'b1;
        n0 = svc.size();
        step(3);
        #2 chk(cpu_irq == 0, "R8 masked source ignored", cpu_irq, 0);
        chk(svc.size() == n0, "R8 nothing serviced", svc.size(), n0);
        write_mask(4'b0000);
        wait_svc();
        chk(last_svc() == 'h20, "R8 unmasked serviced", last_svc(), 'h20);
        pulse_done();
        step(2);

        // R9: non-maskable input
        dev_req[3] = 1'b1;
        wait_svc();
        write_mask(4'b1111);
        nmi_in = 1'b1;
        wait_svc();
        chk(last_svc() == NMIV, "R9 fixed vector taken", last_svc(), NMIV);
        nmi_in = 1'b0;
        pulse_done();
        pulse_done();
        step(3);

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule